// File: doc/BRIEF.md
# Toeplitz Hash Engine

This block computes the 32-bit Toeplitz hash that receive-side scaling uses to spread flows across queues. It hashes a byte stream made of header fields, such as IPv4 addresses and transport ports, under a secret key held inside the block. Software, or a neighbouring block, loads the key one byte at a time through a write port into a 40-byte register file.

Field bytes arrive on a valid/ready interface. A start marker opens a new hash, and a last marker closes the current segment. The engine spends eight clocks on each byte, one per data bit. After the final bit of a byte marked last, it raises a one-cycle done pulse, and the result is then on its hash output.

The hash is kept between segments. A byte without the start marker continues the current hash, so one hash can cover fields that arrive in separate bursts. The key limits how many bytes one hash may cover. A byte beyond that limit is discarded and raises an error that stays set until the next start.

Top module: `toeplitz_hash_engine`

## Requirements
- R1: After reset, hash_value is zero, hash_done and hash_err are low, and in_ready is high.
- R2: Key writes to addresses 0 to KEY_BYTES-1 store the byte at that address. Writes to higher addresses change nothing.
- R3: A byte accepted with in_first set does three things. It clears the accumulator. It loads the 32-bit window from key bytes 0..3, with byte 0 as the most significant byte. It pairs this byte with key byte 4.
- R4: Each data byte is used most significant bit first, over eight clocks. For every 1 bit, the accumulator is XORed with the window. After every bit, the window shifts left by one, and the next bit of the paired key byte enters at the LSB, MSB first. Each later byte of the same hash takes the next key byte in order. With the default key, the IPv4 source/destination pair 66.9.149.187 / 161.142.100.80 hashes to 0x323e8fc2. With ports 2794 and 1766 appended, it hashes to 0x51ccc178.
- R5: Once a byte is accepted, in_ready stays low for the next 8 cycles and is high again in the 9th.
- R6: hash_done goes high for exactly one cycle. This happens 8 cycles after a byte marked in_last is accepted, and never for a byte without in_last.
- R7: hash_value changes only while a byte is being processed. It holds its value once done has been signalled.
- R8: A byte accepted without in_first continues the current hash. The accumulator and window carry over, including across a segment closed by in_last.
- R9: A byte accepted with in_first starts a fresh hash even if a hash is in progress.
- R10: A hash may take at most KEY_BYTES-4 bytes. A byte beyond that limit, accepted without in_first, is discarded. It leaves hash_value unchanged, raises hash_err, and produces no done pulse.
- R11: hash_err stays set, and bytes without in_first are discarded, until a byte with in_first is accepted. That byte clears hash_err in the next cycle.
- R12: A byte without in_first accepted after reset, before any start, is treated as over the limit (R10).
- R13: in_ready stays high while hash_err is set, so the stream keeps draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| key_wr_en | input | 1 | Key byte write strobe |
| key_wr_addr | input | 6 | Key byte address |
| key_wr_data | input | 8 | Key byte value |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine can take a byte |
| in_data | input | 8 | Input byte |
| in_first | input | 1 | Byte opens a new hash |
| in_last | input | 1 | Byte closes the current segment |
| hash_value | output | 32 | Accumulated hash |
| hash_done | output | 1 | One-cycle pulse after the last byte's final bit |
| hash_err | output | 1 | Sticky over-length error |

## Verification
Several properties are checked on every cycle. Loads never overlap a running byte, and a byte runs for its full eight steps. The done pulse lasts one cycle and follows a processing step. The hash holds while nothing is processed. Error and done are never high together, an error keeps in_ready high, and a start clears the error.

Only the directed scenarios can show the hash values themselves. The bench compares them against published receive-side-scaling vectors and against an independent bit-level model, including results split across segments, a restart in mid-hash, the exact 36-byte limit and ignored key writes.

// File: rtl/toep_pkg.sv
package toep_pkg;

   typedef logic [7:0] byte_t;

   localparam int unsigned BITS_PER_BYTE = 8;

   // Index width able to hold the value n itself.
   function automatic int unsigned cnt_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/toep_key_store.sv
module toep_key_store
   import toep_pkg::*;
#(
   parameter int unsigned KEY_BYTES = 40,
   parameter int unsigned WIN_BYTES = 4,
   parameter int unsigned AW        = 6,
   parameter int unsigned IW        = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [AW-1:0]          wr_addr,
   input  byte_t                  wr_data,
   input  logic [IW-1:0]          rd_idx,
   output byte_t                  rd_byte,
   output logic [WIN_BYTES*8-1:0] win_init
);

   byte_t kreg [KEY_BYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < KEY_BYTES; i++) kreg[i] <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < KEY_BYTES; i++)
            if (wr_addr == AW'(i)) kreg[i] <= wr_data;
      end
   end

   // Window seed: key byte 0 lands in the most significant byte.
   for (genvar g = 0; g < WIN_BYTES; g++) begin : g_win
      assign win_init[(WIN_BYTES-g)*8-1 -: 8] = kreg[g];
   end

   always_comb begin
      rd_byte = '0;
      for (int i = 0; i < KEY_BYTES; i++)
         if (rd_idx == IW'(i)) rd_byte = kreg[i];
   end

endmodule

// File: rtl/toep_bit_core.sv
module toep_bit_core
   import toep_pkg::*;
#(
   parameter int unsigned         HASH_W   = 32,
   parameter logic [HASH_W-1:0]   ACC_INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              restart,
   input  logic [HASH_W-1:0] win_init,
   input  byte_t             data_in,
   input  byte_t             key_in,
   output logic              busy,
   output logic              final_step,
   output logic [HASH_W-1:0] acc_out
);

   localparam int unsigned SW = $clog2(BITS_PER_BYTE);
   localparam logic [SW-1:0] LAST_STEP = SW'(BITS_PER_BYTE - 1);

   logic [HASH_W-1:0] acc, win;
   byte_t             dsh, ksh;
   logic [SW-1:0]     cnt;
   logic              busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= ACC_INIT;
         win    <= '0;
         dsh    <= '0;
         ksh    <= '0;
         cnt    <= '0;
         busy_q <= 1'b0;
      end else if (load) begin
         dsh    <= data_in;
         ksh    <= key_in;
         cnt    <= '0;
         busy_q <= 1'b1;
         if (restart) begin
            acc <= ACC_INIT;
            win <= win_init;
         end
      end else if (busy_q) begin
         if (dsh[7]) acc <= acc ^ win;
         win <= {win[HASH_W-2:0], ksh[7]};
         dsh <= {dsh[6:0], 1'b0};
         ksh <= {ksh[6:0], 1'b0};
         cnt <= cnt + 1'b1;
         if (cnt == LAST_STEP) busy_q <= 1'b0;
      end
   end

   assign busy       = busy_q;
   assign final_step = busy_q && (cnt == LAST_STEP);
   assign acc_out    = acc;

   p_load_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy_q);
   p_run_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt != LAST_STEP) |=> busy_q);
   p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (busy_q && cnt == '0));

endmodule

// File: rtl/toeplitz_hash_engine.sv
module toeplitz_hash_engine
   import toep_pkg::*;
#(
   parameter int unsigned       KEY_BYTES = 40,
   parameter int unsigned       HASH_W    = 32,
   parameter logic [HASH_W-1:0] ACC_INIT  = '0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         key_wr_en,
   input  logic [$clog2(KEY_BYTES)-1:0] key_wr_addr,
   input  logic [7:0]                   key_wr_data,
   input  logic                         in_valid,
   output logic                         in_ready,
   input  logic [7:0]                   in_data,
   input  logic                         in_first,
   input  logic                         in_last,
   output logic [HASH_W-1:0]            hash_value,
   output logic                         hash_done,
   output logic                         hash_err
);

   localparam int unsigned WIN_BYTES = HASH_W / 8;
   localparam int unsigned AW        = $clog2(KEY_BYTES);
   localparam int unsigned IW        = cnt_bits(KEY_BYTES);
   localparam logic [IW-1:0] PTR_END   = IW'(KEY_BYTES);
   localparam logic [IW-1:0] PTR_FIRST = IW'(WIN_BYTES);

   if (HASH_W < 8 || (HASH_W % 8) != 0) begin : g_bad_width
      $error("HASH_W must be a positive multiple of 8");
   end
   if (KEY_BYTES < WIN_BYTES + 1) begin : g_bad_key
      $error("KEY_BYTES must exceed the window size in bytes");
   end

   logic              core_busy, core_final, core_load;
   logic [HASH_W-1:0] win_init;
   byte_t             key_byte;
   logic [IW-1:0]     ptr, rd_idx;
   logic              err_q, done_q, last_q;
   logic              accept, overflow, drop;

   assign in_ready = !core_busy;
   assign accept   = in_valid && in_ready;
   assign overflow = !in_first && (ptr == PTR_END);
   assign drop     = !in_first && (overflow || err_q);
   assign core_load = accept && !drop;
   assign rd_idx   = in_first ? PTR_FIRST : ptr;

   toep_key_store #(
      .KEY_BYTES(KEY_BYTES), .WIN_BYTES(WIN_BYTES), .AW(AW), .IW(IW)
   ) u_keys (
      .clk(clk), .rst_n(rst_n),
      .wr_en(key_wr_en), .wr_addr(key_wr_addr), .wr_data(key_wr_data),
      .rd_idx(rd_idx), .rd_byte(key_byte), .win_init(win_init)
   );

   toep_bit_core #(.HASH_W(HASH_W), .ACC_INIT(ACC_INIT)) u_core (
      .clk(clk), .rst_n(rst_n),
      .load(core_load), .restart(in_first),
      .win_init(win_init), .data_in(in_data), .key_in(key_byte),
      .busy(core_busy), .final_step(core_final), .acc_out(hash_value)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr    <= PTR_END;   // no hash open: a continuation is an error
         err_q  <= 1'b0;
         done_q <= 1'b0;
         last_q <= 1'b0;
      end else begin
         done_q <= core_final && last_q;
         if (core_load) begin
            last_q <= in_last;
            ptr    <= rd_idx + 1'b1;
         end
         if (accept && in_first)      err_q <= 1'b0;
         else if (accept && overflow) err_q <= 1'b1;
      end
   end

   assign hash_done = done_q;
   assign hash_err  = err_q;

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hash_done |=> !hash_done);
   p_done_after_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hash_done |-> $past(core_busy));
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(core_busy) && !$past(accept)) |-> $stable(hash_value));
   p_err_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      hash_err |-> !hash_done);
   p_err_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_first) |=> !hash_err);
   p_err_ready_r13: assert property (@(posedge clk) disable iff (!rst_n)
      hash_err |-> in_ready);

endmodule

// File: tb/tb_toeplitz_hash_engine.sv
module tb_toeplitz_hash_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        key_wr_en = 1'b0;
   logic [5:0]  key_wr_addr = '0;
   logic [7:0]  key_wr_data = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = '0;
   logic        in_first = 1'b0;
   logic        in_last = 1'b0;
   logic [31:0] hash_value;
   logic        hash_done;
   logic        hash_err;

   always #5 clk = ~clk;

   toeplitz_hash_engine dut (
      .clk(clk), .rst_n(rst_n),
      .key_wr_en(key_wr_en), .key_wr_addr(key_wr_addr), .key_wr_data(key_wr_data),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_first(in_first), .in_last(in_last),
      .hash_value(hash_value), .hash_done(hash_done), .hash_err(hash_err)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [7:0] kb  [40];
   logic [7:0] msg [64];

   logic [7:0] rss_key [40] = '{
      8'h6d, 8'h5a, 8'h56, 8'hda, 8'h25, 8'h5b, 8'h0e, 8'hc2,
      8'h41, 8'h67, 8'h25, 8'h3d, 8'h43, 8'ha3, 8'h8f, 8'hb0,
      8'hd0, 8'hca, 8'h2b, 8'hcb, 8'hae, 8'h7b, 8'h30, 8'hb4,
      8'h77, 8'hcb, 8'h2d, 8'ha3, 8'h80, 8'h30, 8'hf2, 8'h0c,
      8'h6a, 8'h42, 8'hb7, 8'h3b, 8'hbe, 8'hac, 8'h01, 8'hfa};

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // Independent bit-level model over msg[0..n-1] with key kb.
   function automatic logic [31:0] model(input int n);
      logic [31:0] win = {kb[0], kb[1], kb[2], kb[3]};
      logic [31:0] acc = '0;
      for (int b = 0; b < n; b++) begin
         for (int i = 7; i >= 0; i--) begin
            if (msg[b][i]) acc = acc ^ win;
            win = {win[30:0], kb[4+b][i]};
         end
      end
      return acc;
   endfunction

   task automatic write_key(input int addr, input logic [7:0] val);
      @(negedge clk);
      key_wr_en = 1'b1; key_wr_addr = 6'(addr); key_wr_data = val;
      @(negedge clk);
      key_wr_en = 1'b0;
   endtask

   task automatic load_rss_key();
      for (int i = 0; i < 40; i++) begin
         kb[i] = rss_key[i];
         write_key(i, rss_key[i]);
      end
   endtask

   task automatic set_vec1();
      logic [7:0] v [12] = '{8'h42, 8'h09, 8'h95, 8'hbb, 8'ha1, 8'h8e,
                             8'h64, 8'h50, 8'h0a, 8'hea, 8'h06, 8'he6};
      for (int i = 0; i < 12; i++) msg[i] = v[i];
   endtask

   // Returns at the negedge right after the accepting edge.
   task automatic send_byte(input logic [7:0] d, input logic f, input logic l);
      int guard = 0;
      @(negedge clk);
      while (!in_ready && guard < 50) begin @(negedge clk); guard++; end
      in_valid = 1'b1; in_data = d; in_first = f; in_last = l;
      @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
   endtask

   // Counts negedges until done; returns 0 if none within lim.
   task automatic wait_done(input int lim, output int at);
      at = 0;
      for (int k = 1; k <= lim; k++) begin
         @(negedge clk);
         if (hash_done && at == 0) at = k;
         if (at != 0) break;
      end
   endtask

   task automatic send_msg(input int n, input bit last_on_end, input bit first_on_start);
      for (int i = 0; i < n; i++)
         send_byte(msg[i], (i == 0) && first_on_start, last_on_end && (i == n-1));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      chk(hash_value == 0, "R1 hash_value", hash_value, 0);
      chk(!hash_done && !hash_err, "R1 done/err", {hash_done, hash_err}, 0);
      chk(in_ready, "R1 in_ready", in_ready, 1);
   endtask

   task automatic t_cont_after_reset();
      send_byte(8'h11, 1'b0, 1'b1);
      chk(hash_err, "R12 continuation before any start flags error", hash_err, 1);
      chk(hash_value == 0, "R12 hash untouched", hash_value, 0);
   endtask

   task automatic t_vectors();
      int at;
      set_vec1();
      send_msg(8, 1'b1, 1'b1);
      wait_done(12, at);
      chk(!hash_err, "R11 start clears error", hash_err, 0);
      chk(at == 8, "R6 done 8 cycles after last byte", at, 8);
      chk(hash_value == 32'h323e8fc2, "R3 R4 IPv4 vector", hash_value, 32'h323e8fc2);
      @(negedge clk);
      chk(!hash_done, "R6 done lasts one cycle", hash_done, 0);
      send_msg(12, 1'b1, 1'b1);
      wait_done(12, at);
      chk(hash_value == 32'h51ccc178, "R4 IPv4+ports vector", hash_value, 32'h51ccc178);
      chk(hash_value == model(12), "R4 model agreement", hash_value, model(12));
      repeat (5) @(negedge clk);
      chk(hash_value == 32'h51ccc178, "R7 hash holds after done", hash_value, 32'h51ccc178);
   endtask

   task automatic t_ready_window();
      int lows = 0;
      send_byte(8'h5a, 1'b1, 1'b1);
      chk(!in_ready, "R5 ready low after accept", in_ready, 0);
      for (int k = 1; k <= 7; k++) begin
         @(negedge clk);
         if (!in_ready) lows++;
      end
      chk(lows == 7, "R5 ready low 8 cycles", lows, 7);
      @(negedge clk);
      chk(in_ready, "R5 ready back in 9th cycle", in_ready, 1);
   endtask

   task automatic t_segments();
      int at;
      set_vec1();
      send_msg(8, 1'b1, 1'b1);
      wait_done(12, at);
      chk(hash_value == model(8), "R8 first segment", hash_value, model(8));
      for (int i = 8; i < 12; i++) send_byte(msg[i], 1'b0, i == 11);
      wait_done(12, at);
      chk(at == 8, "R6 done for continued segment", at, 8);
      chk(hash_value == 32'h51ccc178, "R8 continued hash", hash_value, 32'h51ccc178);
   endtask

   task automatic t_no_done_mid();
      int at;
      send_byte(8'h33, 1'b1, 1'b0);
      wait_done(12, at);
      chk(at == 0, "R6 no done without last marker", at, 0);
   endtask

   task automatic t_restart();
      int at;
      send_byte(8'hff, 1'b1, 1'b0);
      send_byte(8'h77, 1'b0, 1'b0);
      set_vec1();
      send_msg(12, 1'b1, 1'b1);
      wait_done(12, at);
      chk(hash_value == 32'h51ccc178, "R9 restart mid-hash", hash_value, 32'h51ccc178);
   endtask

   task automatic t_key_oob();
      int at;
      for (int a = 40; a < 64; a++) write_key(a, 8'hff);
      set_vec1();
      send_msg(12, 1'b1, 1'b1);
      wait_done(12, at);
      chk(hash_value == 32'h51ccc178, "R2 out-of-range key writes ignored",
          hash_value, 32'h51ccc178);
   endtask

   task automatic t_overflow();
      int at;
      logic [31:0] held;
      for (int i = 0; i < 40; i++) begin
         kb[i] = 8'(i * 37 + 11);
         write_key(i, kb[i]);
      end
      for (int i = 0; i < 36; i++) msg[i] = 8'(i * 13 + 5);
      send_msg(36, 1'b1, 1'b1);
      wait_done(12, at);
      chk(hash_value == model(36), "R2 R4 full-length hash, new key", hash_value, model(36));
      chk(!hash_err, "R10 no error at exact limit", hash_err, 0);
      held = hash_value;
      send_byte(8'hc3, 1'b0, 1'b1);
      chk(hash_err, "R10 error on byte past limit", hash_err, 1);
      chk(in_ready, "R13 ready high in error", in_ready, 1);
      wait_done(12, at);
      chk(at == 0, "R10 no done for discarded byte", at, 0);
      chk(hash_value == held, "R10 hash unchanged", hash_value, held);
      send_byte(8'h3c, 1'b0, 1'b1);
      chk(hash_err && in_ready, "R11 error sticky", {hash_err, in_ready}, 2'b11);
      repeat (9) @(negedge clk);
      chk(hash_value == held, "R11 discarded while in error", hash_value, held);
      msg[0] = 8'h9d;
      send_byte(msg[0], 1'b1, 1'b1);
      chk(!hash_err, "R11 start clears error", hash_err, 0);
      wait_done(12, at);
      chk(hash_value == model(1), "R9 fresh hash after error", hash_value, model(1));
   endtask

   initial begin
      t_reset();
      t_cont_after_reset();
      load_rss_key();
      t_vectors();
      t_ready_window();
      t_segments();
      t_no_done_mid();
      t_restart();
      t_key_oob();
      t_overflow();
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog all-requirements act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule